// File: doc/BRIEF.md
# Serial Configuration Store with Signature and Security Lock

This block is the non-volatile style configuration memory that sits behind a small programmable logic array. It keeps 5828 array and macrocell mode bits, a 64-bit user signature, and a single security lock bit. It presents the array bits and the signature as parallel outputs to the logic that consumes them. It is loaded and inspected through a narrow serial port. A command is started by a one-cycle `cmd_go` pulse with a code on `cmd`. After that, each `shift_en` strobe moves one bit in on `sdi` or presents the next bit on `sdo`. Reset models an erased store.

The bit space runs from address 0 to 5891. The array occupies 0..5827 and the signature occupies 5828..5891. Every serial transfer walks the addresses upward, lowest address first. A standard array-only image is loaded by programming 5828 bits and then ending the transfer. The signature then keeps its erased value. Once the lock is set, the array can no longer be read or programmed, but the signature can still be read. Only an erase releases the lock.

Command codes on `cmd`: 0 no-op or abort, 1 erase, 2 program from address 0, 3 read from address 0, 4 program from address 5828, 5 read from address 5828, 6 set lock, 7 no-op or abort.

Top module: `cfg_store`

## Requirements
- R1: After reset all array bits, all signature bits and `secure` are 0, and `refused`, `busy` and `sdo` are 0.
- R2: Command 2 or 4 sets `busy`. Each `shift_en` strobe then writes `sdi` into the current address and advances to the next address. Command 2 starts at address 0, and array bit k (`cfg_array[k]`) takes the k-th bit shifted. After the strobe at address 5891, `busy` drops.
- R3: If a program transfer is ended after 5828 bits by issuing command 0, the array is loaded and every signature bit keeps its erased value 0.
- R4: Address 5828+j holds signature bit 63-j (`sig_word[63-j]`). Signature bytes therefore run from byte 7 down to byte 0, each most significant bit first. Command 4 starts programming at address 5828.
- R5: During a read (command 3 or 5), `sdo` shows the bit at the current address, and each strobe advances the address. Command 5 starts at 5828. A read never changes stored bits.
- R6: Command 6 sets `secure`. A read with command 3 while `secure` is 1 sets `refused`. During that read, addresses below 5828 read as 1 and signature addresses read their true value.
- R7: While `secure` is 1, command 5 returns the true signature and leaves `refused` at 0.
- R8: While `secure` is 1, command 2 or 4 sets `refused`, leaves `busy` at 0, and no array or signature bit changes.
- R9: Command 1 clears every array bit, every signature bit and `secure` in one cycle. No other command clears `secure`.
- R10: A strobe while `busy` is 0 has no effect. When `cmd_go` and `shift_en` are high in the same cycle, the command takes effect and no bit is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | One-cycle command start pulse |
| cmd | input | 3 | Command code |
| shift_en | input | 1 | Serial shift strobe, one bit per cycle |
| sdi | input | 1 | Serial data in for program transfers |
| sdo | output | 1 | Serial data out, bit at current address during reads, else 0 |
| busy | output | 1 | A program or read transfer is in progress |
| refused | output | 1 | The last command was refused by the lock |
| secure | output | 1 | Security lock state |
| cfg_array | output | 5828 | Parallel array and mode bits |
| sig_word | output | 64 | Parallel user signature |

## Verification
A wrong address counter shows up on `sdo` at the very first strobe whose bit differs from its neighbour. It also appears in `cfg_array` or `sig_word` as soon as a program transfer writes a bit into the wrong position. A lock bit in the wrong state shows up in the next command cycle: `refused` is wrong after a read or program command, and after the first strobe the array bits read back as all ones or as true data. A stale transfer mode is exposed by a strobe while idle that alters the parallel outputs in the following cycle. A missed end of transfer is exposed by `busy` staying high after address 5891.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_ERASE    = 3'd1,
    CMD_PROG     = 3'd2,
    CMD_READ     = 3'd3,
    CMD_PROG_SIG = 3'd4,
    CMD_READ_SIG = 3'd5,
    CMD_LOCK     = 3'd6,
    CMD_ABORT    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    XFER_IDLE = 2'd0,
    XFER_PROG = 2'd1,
    XFER_READ = 2'd2
  } xfer_e;
endpackage

// File: rtl/cfg_xfer_ctrl.sv
module cfg_xfer_ctrl
  import cfg_store_pkg::*;
#(
  parameter int ARRAY_BITS = 5828,
  parameter int SIG_BITS   = 64,
  localparam int TOTAL     = ARRAY_BITS + SIG_BITS,
  localparam int AW        = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic [2:0]    cmd,
  input  logic          shift_en,
  input  logic          locked,
  output logic [AW-1:0] addr,
  output logic          wr_en,
  output logic          rd_en,
  output logic          erase,
  output logic          set_lock,
  output logic          busy,
  output logic          refused
);
  localparam logic [AW-1:0] SIG_BASE = AW'(ARRAY_BITS);
  localparam logic [AW-1:0] LAST     = AW'(TOTAL - 1);

  xfer_e         mode_q, mode_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          ref_q, ref_d;

  always_comb begin
    mode_d   = mode_q;
    addr_d   = addr_q;
    ref_d    = ref_q;
    wr_en    = 1'b0;
    erase    = 1'b0;
    set_lock = 1'b0;
    if (cmd_go) begin
      mode_d = XFER_IDLE;
      ref_d  = 1'b0;
      case (cmd_e'(cmd))
        CMD_ERASE: erase = 1'b1;
        CMD_LOCK:  set_lock = 1'b1;
        CMD_PROG, CMD_PROG_SIG: begin
          if (locked) begin
            ref_d = 1'b1;
          end else begin
            mode_d = XFER_PROG;
            addr_d = (cmd_e'(cmd) == CMD_PROG) ? '0 : SIG_BASE;
          end
        end
        CMD_READ: begin
          mode_d = XFER_READ;
          addr_d = '0;
          ref_d  = locked;
        end
        CMD_READ_SIG: begin
          mode_d = XFER_READ;
          addr_d = SIG_BASE;
        end
        default: mode_d = XFER_IDLE;
      endcase
    end else if (shift_en && (mode_q != XFER_IDLE)) begin
      wr_en = (mode_q == XFER_PROG);
      if (addr_q == LAST) mode_d = XFER_IDLE;
      else                addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XFER_IDLE;
      addr_q <= '0;
      ref_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      addr_q <= addr_d;
      ref_q  <= ref_d;
    end
  end

  assign addr    = addr_q;
  assign rd_en   = (mode_q == XFER_READ);
  assign busy    = (mode_q != XFER_IDLE);
  assign refused = ref_q;
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int ARRAY_BITS = 5828,
  parameter int SIG_BITS   = 64,
  localparam int TOTAL     = ARRAY_BITS + SIG_BITS,
  localparam int AW        = $clog2(TOTAL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  wr_en,
  input  logic                  wr_bit,
  input  logic                  rd_en,
  input  logic                  erase,
  input  logic                  set_lock,
  output logic                  locked,
  output logic                  rd_bit,
  output logic [ARRAY_BITS-1:0] array_bits,
  output logic [SIG_BITS-1:0]   sig_bits
);
  localparam logic [AW-1:0] SIG_BASE = AW'(ARRAY_BITS);

  logic [TOTAL-1:0] cell_q, cell_d;
  logic             lock_q, lock_d;

  always_comb begin
    cell_d = cell_q;
    lock_d = lock_q;
    if (erase) begin
      cell_d = '0;
      lock_d = 1'b0;
    end else begin
      if (wr_en)    cell_d[addr] = wr_bit;
      if (set_lock) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
      lock_q <= 1'b0;
    end else begin
      cell_q <= cell_d;
      lock_q <= lock_d;
    end
  end

  assign array_bits = cell_q[ARRAY_BITS-1:0];

  // Ascending signature address walks from the top bit down.
  for (genvar j = 0; j < SIG_BITS; j++) begin : g_sig
    assign sig_bits[SIG_BITS-1-j] = cell_q[ARRAY_BITS+j];
  end

  // Array bits are masked to ones while locked; signature is always visible.
  always_comb begin
    if (!rd_en)                               rd_bit = 1'b0;
    else if (lock_q && (addr < SIG_BASE))     rd_bit = 1'b1;
    else                                      rd_bit = cell_q[addr];
  end

  assign locked = lock_q;
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int ARRAY_BITS = 5828,
  parameter int SIG_BITS   = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_go,
  input  logic [2:0]            cmd,
  input  logic                  shift_en,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  busy,
  output logic                  refused,
  output logic                  secure,
  output logic [ARRAY_BITS-1:0] cfg_array,
  output logic [SIG_BITS-1:0]   sig_word
);
  localparam int TOTAL = ARRAY_BITS + SIG_BITS;
  localparam int AW    = $clog2(TOTAL);

  logic [AW-1:0] addr;
  logic          wr_en, rd_en, erase, set_lock, locked;

  cfg_xfer_ctrl #(.ARRAY_BITS(ARRAY_BITS), .SIG_BITS(SIG_BITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .cmd      (cmd),
    .shift_en (shift_en),
    .locked   (locked),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .erase    (erase),
    .set_lock (set_lock),
    .busy     (busy),
    .refused  (refused)
  );

  cfg_bit_store #(.ARRAY_BITS(ARRAY_BITS), .SIG_BITS(SIG_BITS)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_bit     (sdi),
    .rd_en      (rd_en),
    .erase      (erase),
    .set_lock   (set_lock),
    .locked     (locked),
    .rd_bit     (sdo),
    .array_bits (cfg_array),
    .sig_bits   (sig_word)
  );

  assign secure = locked;
endmodule

// File: rtl/cfg_store_checker.sv
module cfg_store_checker #(
  parameter int ARRAY_BITS = 5828,
  parameter int SIG_BITS   = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_go,
  input logic [2:0]            cmd,
  input logic                  sdo,
  input logic                  busy,
  input logic                  refused,
  input logic                  secure,
  input logic [ARRAY_BITS-1:0] cfg_array,
  input logic [SIG_BITS-1:0]   sig_word
);
  logic erase_go;
  assign erase_go = cmd_go && (cmd == 3'd1);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    secure && !erase_go |=> secure); // R9

  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !secure && (cfg_array == '0) && (sig_word == '0)); // R9

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    secure && !erase_go |=> $stable(cfg_array) && $stable(sig_word)); // R8

  AST_LOCKED_PROG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && secure && ((cmd == 3'd2) || (cmd == 3'd4)) |=> refused && !busy); // R8

  AST_READ_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && (cmd == 3'd3) |=> refused == $past(secure)); // R6

  AST_SIG_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && (cmd == 3'd5) |=> !refused && busy); // R7

  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_go |=> $stable(cfg_array) && $stable(sig_word) && $stable(secure)); // R10

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo); // R5
endmodule

bind cfg_store cfg_store_checker #(.ARRAY_BITS(ARRAY_BITS), .SIG_BITS(SIG_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_go    (cmd_go),
  .cmd       (cmd),
  .sdo       (sdo),
  .busy      (busy),
  .refused   (refused),
  .secure    (secure),
  .cfg_array (cfg_array),
  .sig_word  (sig_word)
);

// File: tb/cfg_store_tb.sv
`timescale 1ns/1ps
module cfg_store_tb;
  localparam int AB = 5828;
  localparam int SB = 64;
  localparam int TOT = AB + SB;
  localparam logic [63:0] SIGV = 64'hA5C3_0F1E_7788_9BDE;

  logic clk, rst_n, cmd_go, shift_en, sdi;
  logic [2:0] cmd;
  logic sdo, busy, refused, secure;
  logic [AB-1:0] cfg_array;
  logic [SB-1:0] sig_word;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [AB-1:0] exp_a, exp_b;
  logic [SB-1:0] exp_bsig;

  cfg_store u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd(cmd), .shift_en(shift_en),
    .sdi(sdi), .sdo(sdo), .busy(busy), .refused(refused), .secure(secure),
    .cfg_array(cfg_array), .sig_word(sig_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit pat_a(int k);
    return ((k * 13) % 7) < 3;
  endfunction
  function automatic bit pat_b(int k);
    return ((k % 5) == 1) || ((k % 11) == 0);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compare sdo before each strobe edge of a read
  always @(negedge clk) begin
    if (mon_on && shift_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected read bit actual=%0b expected=none", sdo);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (sdo !== e) begin
          errors++;
          $display("FAIL %s sdo actual=%0b expected=%0b", t, sdo, e);
        end
      end
    end
  end

  task automatic do_cmd(logic [2:0] c);
    cmd = c; cmd_go = 1'b1;
    @(posedge clk); #1;
    cmd_go = 1'b0;
  endtask

  task automatic shift_bit(bit b);
    sdi = b; shift_en = 1'b1;
    @(posedge clk); #1;
    shift_en = 1'b0;
  endtask

  task automatic push_exp(bit b, string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_go = 1'b0; cmd = 3'd0; shift_en = 1'b0; sdi = 1'b0;
    for (int k = 0; k < AB; k++) begin
      exp_a[k] = pat_a(k);
      exp_b[k] = pat_b(k);
    end
    for (int j = 0; j < SB; j++) exp_bsig[SB-1-j] = pat_b(AB + j);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check("R1", {63'd0, secure}, 64'd0, "secure");
    check("R1", {63'd0, refused}, 64'd0, "refused");
    check("R1", {63'd0, busy}, 64'd0, "busy");
    check("R1", {63'd0, sdo}, 64'd0, "sdo");
    check("R1", {63'd0, cfg_array == '0}, 64'd1, "array erased");
    check("R1", sig_word, 64'd0, "signature");

    // R2 / R3 standard image of array bits only
    do_cmd(3'd2);
    check("R2", {63'd0, busy}, 64'd1, "busy after program cmd");
    for (int k = 0; k < AB; k++) shift_bit(pat_a(k));
    check("R2", {63'd0, busy}, 64'd1, "busy before signature area");
    do_cmd(3'd0);
    check("R2", {63'd0, busy}, 64'd0, "busy after abort");
    check("R2", {63'd0, cfg_array === exp_a}, 64'd1, "array image");
    check("R3", sig_word, 64'd0, "signature left erased");

    // R5 full readback, unlocked
    do_cmd(3'd3);
    check("R5", {63'd0, refused}, 64'd0, "refused on open read");
    for (int k = 0; k < TOT; k++) push_exp(k < AB ? pat_a(k) : 1'b0, "R5");
    mon_on = 1;
    for (int k = 0; k < TOT; k++) shift_bit(1'b1);
    mon_on = 0;
    check("R5", {63'd0, busy}, 64'd0, "read ends at last address");
    check("R5", {63'd0, cfg_array === exp_a}, 64'd1, "read leaves array");

    // R4 signature programming order
    do_cmd(3'd4);
    for (int i = 0; i < SB; i++) shift_bit(SIGV[63-i]);
    check("R4", sig_word, SIGV, "signature word");
    check("R2", {63'd0, busy}, 64'd0, "busy after address 5891");
    check("R4", {63'd0, cfg_array === exp_a}, 64'd1, "array untouched by sig program");

    do_cmd(3'd5);
    for (int i = 0; i < SB; i++) push_exp(SIGV[63-i], "R5");
    mon_on = 1;
    for (int i = 0; i < SB; i++) shift_bit(1'b0);
    mon_on = 0;

    // R6 lock, then array read masked
    do_cmd(3'd6);
    check("R6", {63'd0, secure}, 64'd1, "secure after lock");
    check("R6", {63'd0, refused}, 64'd0, "lock cmd not refused");
    do_cmd(3'd3);
    check("R6", {63'd0, refused}, 64'd1, "refused on locked read");
    for (int k = 0; k < TOT; k++) push_exp(k < AB ? 1'b1 : SIGV[63-(k-AB)], "R6");
    mon_on = 1;
    for (int k = 0; k < TOT; k++) shift_bit(1'b0);
    mon_on = 0;

    // R7 signature still readable
    do_cmd(3'd5);
    check("R7", {63'd0, refused}, 64'd0, "sig read not refused");
    for (int i = 0; i < SB; i++) push_exp(SIGV[63-i], "R7");
    mon_on = 1;
    for (int i = 0; i < SB; i++) shift_bit(1'b1);
    mon_on = 0;

    // R8 program refused while locked
    do_cmd(3'd2);
    check("R8", {63'd0, refused}, 64'd1, "refused program");
    check("R8", {63'd0, busy}, 64'd0, "busy on refused program");
    for (int k = 0; k < 10; k++) shift_bit(~pat_a(k));
    check("R8", {63'd0, cfg_array === exp_a}, 64'd1, "array unchanged");
    do_cmd(3'd4);
    check("R8", {63'd0, refused}, 64'd1, "refused sig program");
    for (int k = 0; k < 5; k++) shift_bit(~SIGV[63-k]);
    check("R8", sig_word, SIGV, "signature unchanged");

    // R9 only erase clears the lock
    do_cmd(3'd0);
    do_cmd(3'd7);
    do_cmd(3'd5);
    do_cmd(3'd0);
    check("R9", {63'd0, secure}, 64'd1, "lock survives other commands");
    do_cmd(3'd1);
    check("R9", {63'd0, secure}, 64'd0, "lock cleared by erase");
    check("R9", {63'd0, cfg_array == '0}, 64'd1, "array erased");
    check("R9", sig_word, 64'd0, "signature erased");
    check("R9", {63'd0, refused}, 64'd0, "erase not refused");

    // R10 idle strobes, and command winning over strobe
    for (int k = 0; k < 3; k++) shift_bit(1'b1);
    check("R10", {63'd0, cfg_array == '0}, 64'd0 + 1, "idle strobe no write");
    check("R10", sig_word, 64'd0, "idle strobe no sig write");
    cmd = 3'd2; cmd_go = 1'b1; shift_en = 1'b1; sdi = 1'b1;
    @(posedge clk); #1;
    cmd_go = 1'b0; shift_en = 1'b0;
    check("R10", {63'd0, cfg_array[0]}, 64'd0, "no write with command");
    check("R10", {63'd0, busy}, 64'd1, "command taken with strobe");

    // R2 full extended image, then R5 readback
    for (int k = 0; k < TOT; k++) shift_bit(pat_b(k));
    check("R2", {63'd0, busy}, 64'd0, "busy after full image");
    check("R2", {63'd0, cfg_array === exp_b}, 64'd1, "full image array");
    check("R4", sig_word, exp_bsig, "full image signature");
    do_cmd(3'd3);
    for (int k = 0; k < TOT; k++) push_exp(pat_b(k), "R5");
    mon_on = 1;
    for (int k = 0; k < TOT; k++) shift_bit(1'b0);
    mon_on = 0;
    check("R5", exp_q.size(), 64'd0, "scoreboard drained");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule